// File: doc/BRIEF.md
# Burst Memory Read Sequencer

This block is the command engine of a debug bridge that reads target memory and returns the contents as a byte stream. A host-side command carries an operation code, a start address and a byte count. The engine either reads one byte or walks a range of addresses. It sends read requests to a memory port and forwards each returned byte to an outbound byte stream that uses valid/ready.

The memory port accepts requests under a ready signal, but it returns data a fixed number of cycles later with no way to stall. The engine therefore keeps a small response buffer and a count of requests still in flight. A request goes out only when a buffer slot is reserved for its answer, so a slow consumer can never cause a returned byte to be dropped. Single-byte reads take the same response path as bursts. A one-byte command is treated as a burst of length one.

Two counters track progress: requests issued and bytes delivered. The engine returns to idle only after both reach the command length. A paced mode can be chosen per command. In that mode each request waits until the previous answer has come back, which is useful for isolating timing faults.

Top module: `bmr_seq`

## Requirements
- R1: `cmd_ready` is high exactly when the engine is idle. Address, length, operation and pace flag are captured on the cycle `cmd_valid` and `cmd_ready` are both high, and later changes on the command inputs have no effect on a running command.
- R2: A single-byte command (`cmd_op` = 0) issues one memory request at `cmd_addr` and delivers the one returned byte on `out_data`.
- R3: A burst (`cmd_op` = 1) requests ascending consecutive addresses starting at `cmd_addr`. When memory is always ready and the response buffer is empty, the first RSP_DEPTH requests go out on consecutive cycles.
- R4: A burst of length N delivers exactly N bytes, in address order, each equal to the memory data for its address.
- R5: No command ever issues more requests than its length.
- R6: Requests in flight plus buffered bytes never exceed RSP_DEPTH, so no returned byte is lost however slowly `out_ready` is asserted.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R8: With `cmd_pace` = 1, at most one request is in flight. A new request is issued only after the previous response has arrived.
- R9: A burst of length 0 issues no requests and delivers no bytes, and `cmd_ready` is high again on the cycle after acceptance.
- R10: `cmd_ready` rises on the cycle right after the last output byte is taken.
- R11: For a single-byte command the `cmd_len` value is ignored. Exactly one byte is delivered whatever `cmd_len` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted |
| cmd_op | input | 1 | 0 = single byte, 1 = burst |
| cmd_addr | input | ADDR_W | Start address |
| cmd_len | input | LEN_W | Burst byte count |
| cmd_pace | input | 1 | 1 = one request in flight at a time |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Read request address |
| mem_rsp_valid | input | 1 | Read data returned (cannot be stalled) |
| mem_rsp_data | input | DATA_W | Returned byte |
| out_valid | output | 1 | Outbound byte valid |
| out_ready | input | 1 | Consumer takes byte |
| out_data | output | DATA_W | Outbound byte |

## Verification
The bench builds the engine with RSP_DEPTH = 3. This is not a power of two, so it selects the modulo pointer-wrap variant of the response buffer, and the credit limit is reached after only three requests. A memory model with a three-cycle latency keeps the buffer full of in-flight requests. The model has a randomly stalling request port, and a randomly stalling consumer runs alongside it, so the credit gate and output hold are exercised under heavy backpressure. LEN_W = 16 allows a 128-byte burst, and ADDR_W = 32 covers full-range start addresses.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
   typedef enum logic {
      OP_BYTE  = 1'b0,
      OP_BURST = 1'b1
   } bmr_op_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } bmr_state_e;
endpackage

// File: rtl/bmr_byte_fifo.sv
module bmr_byte_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("bmr_byte_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("bmr_byte_fifo: W must be positive");
   end

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   // pointer wrap: free overflow for power-of-two depth, compare otherwise
   if ((1 << PW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + PW'(1);
      assign rd_nxt = rd_ptr + PW'(1);
   end else begin : g_mod
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
   end

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign dout  = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) store[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full && !pop))
      else $error("response buffer overflow");

   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && empty))
      else $error("response buffer underflow");
endmodule

// File: rtl/bmr_issue.sv
module bmr_issue #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16,
   parameter int DEPTH  = 4,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic              pace,
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  len,
   input  logic [CW-1:0]     buf_count,
   input  logic              rsp_valid,
   input  logic              req_ready,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic [CW-1:0]     in_flight
);
   logic [LEN_W-1:0] req_cnt;
   logic [CW:0]      committed;
   logic             credit_ok, pace_ok, more, req_fire;

   // a slot is reserved for every request before it leaves
   assign committed = {1'b0, in_flight} + {1'b0, buf_count};
   assign credit_ok = committed < (CW + 1)'(DEPTH);
   assign pace_ok   = !pace || (in_flight == '0);
   assign more      = (req_cnt != len);
   assign req_valid = active && more && credit_ok && pace_ok;
   assign req_addr  = base + ADDR_W'(req_cnt);
   assign req_fire  = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_cnt <= '0;
      end else if (start) begin
         req_cnt <= '0;
      end else if (req_fire) begin
         req_cnt <= req_cnt + LEN_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_flight <= '0;
      end else begin
         case ({req_fire, rsp_valid})
            2'b10:   in_flight <= in_flight + CW'(1);
            2'b01:   in_flight <= in_flight - CW'(1);
            default: in_flight <= in_flight;
         endcase
      end
   end

   p_req_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> req_cnt <= len)
      else $error("issued past length");

   p_credit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      committed <= (CW + 1)'(DEPTH))
      else $error("credit exceeded");

   p_pace_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pace && active |-> in_flight <= CW'(1))
      else $error("paced mode overlapped requests");
endmodule

// File: rtl/bmr_seq.sv
module bmr_seq
   import bmr_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int DATA_W    = 8,
   parameter int RSP_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic              cmd_pace,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   localparam int CW = $clog2(RSP_DEPTH + 1);

   if (ADDR_W < 1 || LEN_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("bmr_seq: widths must be positive");
   end
   if (RSP_DEPTH < 2) begin : g_bad_depth
      $error("bmr_seq: RSP_DEPTH must be at least 2");
   end

   bmr_state_e        state;
   bmr_op_e           op_in;
   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  len_q, sent_cnt;
   logic              pace_q, cmd_fire, busy, pop, last_pop;
   logic              buf_empty, buf_full;
   logic [CW-1:0]     buf_count, in_flight;

   assign op_in     = bmr_op_e'(cmd_op);
   assign busy      = (state == ST_RUN);
   assign cmd_ready = !busy;
   assign cmd_fire  = cmd_valid && cmd_ready;
   assign out_valid = !buf_empty;
   assign pop       = out_valid && out_ready;
   assign last_pop  = pop && (sent_cnt == len_q - LEN_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         base_q   <= '0;
         len_q    <= '0;
         pace_q   <= 1'b0;
         sent_cnt <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cmd_fire) begin
                  base_q   <= cmd_addr;
                  len_q    <= (op_in == OP_BURST) ? cmd_len : LEN_W'(1);
                  pace_q   <= cmd_pace;
                  sent_cnt <= '0;
                  if (op_in == OP_BYTE || cmd_len != '0) state <= ST_RUN;
               end
            end
            default: begin
               if (pop) sent_cnt <= sent_cnt + LEN_W'(1);
               if (last_pop) state <= ST_IDLE;
            end
         endcase
      end
   end

   bmr_issue #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W),
      .DEPTH  (RSP_DEPTH)
   ) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cmd_fire),
      .active    (busy),
      .pace      (pace_q),
      .base      (base_q),
      .len       (len_q),
      .buf_count (buf_count),
      .rsp_valid (mem_rsp_valid),
      .req_ready (mem_req_ready),
      .req_valid (mem_req_valid),
      .req_addr  (mem_req_addr),
      .in_flight (in_flight)
   );

   bmr_byte_fifo #(
      .DEPTH (RSP_DEPTH),
      .W     (DATA_W)
   ) u_rsp_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (mem_rsp_valid),
      .din   (mem_rsp_data),
      .pop   (pop),
      .dout  (out_data),
      .empty (buf_empty),
      .full  (buf_full),
      .count (buf_count)
   );

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data))
      else $error("output changed under backpressure");

   p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_fire && cmd_op && cmd_len == '0 |=> cmd_ready && !mem_req_valid)
      else $error("zero-length burst did not complete at once");

   p_idle_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> buf_empty && in_flight == '0)
      else $error("returned to idle with work pending");

   p_no_out_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !out_valid)
      else $error("output byte while idle");
endmodule

// File: tb/bmr_seq_tb.sv
module bmr_seq_tb;
   localparam int ADDR_W = 32;
   localparam int LEN_W  = 16;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 3;
   localparam int LAT    = 3;
   localparam int LIMIT  = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_valid = 1'b0;
   logic              cmd_ready;
   logic              cmd_op = 1'b0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [LEN_W-1:0]  cmd_len = '0;
   logic              cmd_pace = 1'b0;
   logic              mem_req_valid;
   logic              mem_req_ready = 1'b0;
   logic [ADDR_W-1:0] mem_req_addr;
   logic              mem_rsp_valid = 1'b0;
   logic [DATA_W-1:0] mem_rsp_data = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [DATA_W-1:0] out_data;

   always #4 clk = ~clk;

   bmr_seq #(
      .ADDR_W    (ADDR_W),
      .LEN_W     (LEN_W),
      .DATA_W    (DATA_W),
      .RSP_DEPTH (DEPTH)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd_ready     (cmd_ready),
      .cmd_op        (cmd_op),
      .cmd_addr      (cmd_addr),
      .cmd_len       (cmd_len),
      .cmd_pace      (cmd_pace),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .out_valid     (out_valid),
      .out_ready     (out_ready),
      .out_data      (out_data)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit ended  = 0;

   logic [DATA_W-1:0] exp_q [$];
   logic [ADDR_W-1:0] req_next;
   int  req_left = 0, req_idx = 0, last_req_cyc = 0, bout = 0;
   int  mem_pct = 100, out_pct = 100;
   bit  pace_chk = 0, idle_chk = 0, hold_prev = 0;
   logic [DATA_W-1:0] hold_data;
   string cur_tag = "R4";
   logic              pv [LAT];
   logic [DATA_W-1:0] pd [LAT];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DATA_W-1:0] mem_fn(input logic [ADDR_W-1:0] a);
      return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'hA5;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // memory model, consumer and scoreboard monitor
   always @(negedge clk) begin
      int bout_prev;
      if (rst_n) begin
         bout_prev = bout;
         if (idle_chk) begin
            chk(cmd_ready == 1'b1, "R10", "cmd_ready after last byte", cmd_ready, 1);
            idle_chk = 0;
         end
         if (hold_prev) begin
            chk(out_valid == 1'b1, "R7", "valid held", out_valid, 1);
            chk(out_data == hold_data, "R7", "data held", out_data, hold_data);
         end
         mem_rsp_valid = pv[LAT-1];
         mem_rsp_data  = pd[LAT-1];
         if (mem_rsp_valid) bout--;
         for (int i = LAT - 1; i > 0; i--) begin
            pv[i] = pv[i-1];
            pd[i] = pd[i-1];
         end
         pv[0] = 1'b0;
         mem_req_ready = ($urandom % 100) < mem_pct;
         if (mem_req_valid && mem_req_ready) begin
            chk(req_left > 0, "R5", "request beyond length", req_idx, req_idx - 1);
            chk(mem_req_addr == req_next, "R3", "request address", mem_req_addr, req_next);
            if (pace_chk)
               chk(bout_prev == 0, "R8", "request while one in flight", bout_prev, 0);
            if (mem_pct == 100 && req_idx > 0 && req_idx < DEPTH)
               chk(cyc == last_req_cyc + 1, "R3", "back-to-back issue", cyc, last_req_cyc + 1);
            pv[0] = 1'b1;
            pd[0] = mem_fn(mem_req_addr);
            bout++;
            req_next = req_next + 1;
            req_left--;
            req_idx++;
            last_req_cyc = cyc;
         end
         out_ready = ($urandom % 100) < out_pct;
         hold_prev = out_valid && !out_ready;
         hold_data = out_data;
         if (out_valid && out_ready) begin
            chk(cmd_ready == 1'b0, "R1", "ready low while busy", cmd_ready, 0);
            if (exp_q.size() == 0) begin
               chk(0, cur_tag, "unexpected extra byte", out_data, 0);
            end else begin
               logic [DATA_W-1:0] e;
               e = exp_q.pop_front();
               chk(out_data == e, cur_tag, "output byte", out_data, e);
               if (exp_q.size() == 0) idle_chk = 1;
            end
         end
      end
   end

   task automatic run_cmd(input bit op, input logic [ADDR_W-1:0] addr,
                          input int len, input bit pace, input string tag,
                          input int mp, input int op_pct);
      int n;
      n = op ? len : 1;
      for (int i = 0; i < n; i++) exp_q.push_back(mem_fn(addr + ADDR_W'(i)));
      req_next = addr; req_left = n; req_idx = 0;
      cur_tag = tag; mem_pct = mp; out_pct = op_pct; pace_chk = pace;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R1", "ready when idle", cmd_ready, 1);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
      cmd_len = LEN_W'(len); cmd_pace = pace;
      @(negedge clk);
      // scramble command inputs: the engine must use the captured values (R1)
      cmd_valid = 1'b0; cmd_addr = $urandom; cmd_len = LEN_W'($urandom);
      cmd_op = 1'($urandom); cmd_pace = 1'($urandom);
      if (n == 0) begin
         chk(cmd_ready == 1'b1, "R9", "ready after empty burst", cmd_ready, 1);
         for (int k = 0; k < 6; k++) begin
            chk(!mem_req_valid && !out_valid, "R9", "activity on empty burst",
                {mem_req_valid, out_valid}, 0);
            @(negedge clk);
         end
      end else begin
         while (exp_q.size() != 0) @(negedge clk);
         repeat (3) @(negedge clk);
         chk(req_left == 0, "R5", "requests left unissued", req_left, 0);
         chk(req_idx == n, (op ? "R5" : "R11"), "request count", req_idx, n);
      end
   endtask

   initial begin
      for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pd[i] = '0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R1", "reset cmd_ready", cmd_ready, 1);
      chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
      chk(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", mem_req_valid, 0);
      // single byte with a non-trivial length field (R2, R11)
      run_cmd(1'b0, 32'h1000_0040, 77, 1'b0, "R2", 100, 100);
      run_cmd(1'b0, 32'hFFFF_FF00, 0, 1'b0, "R11", 100, 50);
      // full-speed 128-byte burst (R3, R4)
      run_cmd(1'b1, 32'h0000_0100, 128, 1'b0, "R4", 100, 100);
      // heavy backpressure both sides (R6, R7)
      run_cmd(1'b1, 32'h2000_0FF0, 40, 1'b0, "R6", 60, 20);
      // paced mode (R8)
      run_cmd(1'b1, 32'h3000_0000, 16, 1'b1, "R8", 70, 40);
      // zero-length burst (R9)
      run_cmd(1'b1, 32'h4000_0000, 0, 1'b0, "R9", 100, 100);
      // address wrap and short burst after empty one
      run_cmd(1'b1, 32'hFFFF_FFFE, 5, 1'b0, "R4", 100, 70);
      if (!ended) begin
         ended = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      while (cyc < LIMIT) @(posedge clk);
      if (!ended) begin
         ended = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, LIMIT);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule